// File: doc/BRIEF.md
# Ping-Pong Line Buffer Scanout Controller

This block feeds a pixel output stream from two equal on-chip buffers used in alternation. The scanout side pulls one pixel per `px_take` pulse from the active buffer. Meanwhile the block keeps a refill request raised for the other buffer. Each request carries the frame pixel position where filling must start and the byte count that must be written. A producer writes the pixels through a simple write port and then acknowledges. A buffer is usable only after its acknowledge.

When the last pixel of the active buffer has been handed out, the two buffers swap roles. The drained buffer is requested again, this time for the pixels two buffers further on in the frame, wrapping at the frame end. If the next buffer is not full at the swap, an underrun flag rises and the output carries dummy pixels. Recovery is deferred. A restart request is only remembered, and it takes effect at the next vertical sync. At that point the read position returns to frame pixel 0 and both buffers are requested afresh. An optional mode realigns at every vertical sync without any request.

Top module: `pingpong_scanout`

## Requirements
- R1: During and after reset, both buffers are empty and `fill_req` is 2'b11. The fill position of buffer 0 is 0 and that of buffer 1 is BUF_PIX. `underrun`, `px_real` and `frame_done` are low, and `px_data` is DUMMY_PIX.
- R2: `fill_len` always equals BUF_PIX*PIX_W/8, the buffer size in bytes (16 with the defaults).
- R3: When `fill_ack[b]` is high while `fill_req[b]` is high, buffer b becomes full and `fill_req[b]` falls on the next cycle. An acknowledge for a buffer that is not requested has no effect.
- R4: A `px_take` pulse while the active buffer is full, with no underrun and no restart in that cycle, puts the next stored pixel on `px_data` on the following cycle with `px_real` high. Pixels come out in address order.
- R5: After the last pixel of a buffer is taken, reading continues at address 0 of the other buffer. On the next cycle the drained buffer's `fill_req` bit is high, and its fill position is its previous position plus 2*BUF_PIX, modulo FRAME = H_RES*V_RES.
- R6: `frame_done` is high for exactly the output cycle that carries frame pixel FRAME-1, and is low for every other pixel.
- R7: `underrun` rises in either of two cases: a swap finds the other buffer not full, or a take finds the active buffer not full. A take during underrun outputs DUMMY_PIX (0 by default) with `px_real` low and does not advance the read position.
- R8: `underrun` stays high until a restart is applied, even if both buffers are filled in the meantime.
- R9: A `restart_req` pulse is latched and changes nothing until the next `vsync`. A `vsync` with no pending request and with `auto_restart` low changes nothing. A request in the same cycle as `vsync` is applied at that `vsync`.
- R10: An applied restart clears `underrun` and empties both buffers. It raises `fill_req` to 2'b11 with fill positions 0 and BUF_PIX, and the next real pixel is frame pixel 0.
- R11: With `auto_restart` high, every `vsync` applies a restart without any request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vsync | input | 1 | Vertical sync event, one-cycle pulse |
| restart_req | input | 1 | Request a realignment at the next vsync |
| auto_restart | input | 1 | Realign at every vsync |
| px_take | input | 1 | Consumer pulls one pixel |
| px_data | output | PIX_W | Pixel, valid the cycle after a take |
| px_real | output | 1 | px_data holds buffer data (low: dummy) |
| frame_done | output | 1 | Last pixel of the frame is on px_data |
| underrun | output | 1 | Sticky underrun flag |
| fill_req | output | 2 | Refill request per buffer |
| fill_pos | output | 2*POS_W | Frame pixel start per buffer, buffer 0 in the low bits |
| fill_len | output | LEN_W | Bytes to fill per request |
| fill_ack | input | 2 | Fill complete per buffer |
| wr_en | input | 1 | Producer write strobe |
| wr_sel | input | 1 | Buffer written |
| wr_addr | input | ADDR_W | Pixel address in buffer |
| wr_data | input | PIX_W | Pixel written |

## Verification
The bench runs a full frame so that the fill position wraps from 2*BUF_PIX past the end back to zero; a design with a wrong modulo would request pixel 32 or skip a buffer. It then withholds a refill to force a swap-time underrun and checks that dummies continue after both buffers are filled, after a bare vsync and after a bare restart request. A design that recovered early, or applied the restart immediately, would show real pixels or a changed request there. It also checks that auto mode realigns mid-frame, that a request coinciding with vsync takes effect, and that `frame_done` marks only pixel FRAME-1. An off-by-one in the final-pixel compare would move or duplicate that pulse.

// File: rtl/pp_pkg.sv
`timescale 1ns/1ps
// Shared types and helpers for the ping-pong scanout controller.
// Assumes: positions are below 2**31.
package pp_pkg;

    typedef enum logic {BUF_A = 1'b0, BUF_B = 1'b1} buf_id_e;

    // Add a step to a frame position and fold the result back into the frame.
    function automatic int unsigned frame_wrap_add(input int unsigned pos,
                                                   input int unsigned step,
                                                   input int unsigned frame);
        int unsigned sum;
        sum = pos + step;
        if (sum >= frame) sum = sum - frame;
        return sum;
    endfunction

endpackage

// File: rtl/pp_bank_store.sv
`timescale 1ns/1ps
// Two equal pixel banks with one shared write port and one combinational
// read port. Assumes: the producer never writes the bank being read.
module pp_bank_store #(
    parameter int PIX_W = 16,
    parameter int DEPTH = 8
) (
    input  logic                     clk,
    input  logic                     wr_en,
    input  logic                     wr_sel,
    input  logic [$clog2(DEPTH)-1:0] wr_addr,
    input  logic [PIX_W-1:0]         wr_data,
    input  logic                     rd_sel,
    input  logic [$clog2(DEPTH)-1:0] rd_addr,
    output logic [PIX_W-1:0]         rd_data
);

    logic [1:0][PIX_W-1:0] bank_q;

    for (genvar g = 0; g < 2; g++) begin : g_bank
        logic [PIX_W-1:0] mem [DEPTH];

        // Store one producer pixel into this bank.
        always_ff @(posedge clk) begin
            if (wr_en && (wr_sel == 1'(g))) mem[wr_addr] <= wr_data;
        end

        assign bank_q[g] = mem[rd_addr];
    end

    assign rd_data = bank_q[rd_sel];

endmodule

// File: rtl/pp_fill_ctrl.sv
`timescale 1ns/1ps
// Per-buffer fill bookkeeping: full flag, refill request and the frame pixel
// position where the next fill starts. A drain re-requests the buffer two
// buffers further on; a restart rebuilds the state from frame start.
// Assumes: FRAME is a multiple of BUF_PIX and at least 2*BUF_PIX.
module pp_fill_ctrl #(
    parameter int BUF_PIX = 8,
    parameter int FRAME   = 32,
    parameter int POS_W   = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  restart,
    input  logic                  drain,
    input  logic                  drain_sel,
    input  logic [1:0]            ack,
    output logic [1:0]            full,
    output logic [1:0]            req,
    output logic [1:0][POS_W-1:0] pos
);
    import pp_pkg::*;

    localparam int unsigned STEP = 2 * BUF_PIX;

    for (genvar b = 0; b < 2; b++) begin : g_buf
        logic             full_r;
        logic             req_r;
        logic [POS_W-1:0] pos_r;

        // Track the empty/requested/full life cycle of one buffer.
        always_ff @(posedge clk) begin
            if (!rst_n || restart) begin
                full_r <= 1'b0;
                req_r  <= 1'b1;
                pos_r  <= POS_W'(b * BUF_PIX);
            end else if (drain && (drain_sel == 1'(b))) begin
                full_r <= 1'b0;
                req_r  <= 1'b1;
                pos_r  <= POS_W'(frame_wrap_add(int'(pos_r), STEP, FRAME));
            end else if (ack[b] && req_r) begin
                full_r <= 1'b1;
                req_r  <= 1'b0;
            end
        end

        assign full[b] = full_r;
        assign req[b]  = req_r;
        assign pos[b]  = pos_r;
    end

endmodule

// File: rtl/pp_scan_seq.sv
`timescale 1ns/1ps
// Scanout sequencer: walks the active buffer, swaps at its end, tracks the
// frame pixel position, flags underrun and applies deferred restarts at vsync.
// Assumes: rd_q is the combinational read of (rd_sel, rd_addr).
module pp_scan_seq #(
    parameter int                PIX_W     = 16,
    parameter int                BUF_PIX   = 8,
    parameter int                FRAME     = 32,
    parameter int                POS_W     = 5,
    parameter logic [PIX_W-1:0]  DUMMY_PIX = '0
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       vsync,
    input  logic                       restart_req,
    input  logic                       auto_restart,
    input  logic                       px_take,
    input  logic [1:0]                 full,
    input  logic [PIX_W-1:0]           rd_q,
    output logic                       rd_sel,
    output logic [$clog2(BUF_PIX)-1:0] rd_addr,
    output logic                       drain,
    output logic                       restart_apply,
    output logic [PIX_W-1:0]           px_data,
    output logic                       px_real,
    output logic                       frame_done,
    output logic                       underrun
);
    import pp_pkg::*;

    localparam int ADDR_W = $clog2(BUF_PIX);

    logic              rd_buf;
    logic [ADDR_W-1:0] rd_idx;
    logic [POS_W-1:0]  scan_pos;
    logic              pend;
    logic              take_ok;
    logic              last_px;

    assign restart_apply = vsync && (pend || restart_req || auto_restart);
    assign take_ok       = px_take && !restart_apply && !underrun && full[rd_buf];
    assign last_px       = (rd_idx == ADDR_W'(BUF_PIX - 1));
    assign drain         = take_ok && last_px;
    assign rd_sel        = rd_buf;
    assign rd_addr       = rd_idx;

    // Remember a restart request until a vsync applies it.
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= 1'b0;
        else        pend <= (pend || restart_req) && !restart_apply;
    end

    // Advance the read pointer and frame position on every served take.
    always_ff @(posedge clk) begin
        if (!rst_n || restart_apply) begin
            rd_buf   <= BUF_A;
            rd_idx   <= '0;
            scan_pos <= '0;
        end else if (take_ok) begin
            scan_pos <= POS_W'(frame_wrap_add(int'(scan_pos), 1, FRAME));
            if (last_px) begin
                rd_idx <= '0;
                rd_buf <= !rd_buf;
            end else begin
                rd_idx <= rd_idx + 1'b1;
            end
        end
    end

    // Raise the sticky underrun flag; only an applied restart clears it.
    always_ff @(posedge clk) begin
        if (!rst_n || restart_apply)               underrun <= 1'b0;
        else if (px_take && !underrun && !full[rd_buf]) underrun <= 1'b1;
        else if (drain && !full[!rd_buf])          underrun <= 1'b1;
    end

    // Register the pixel output, dummy when nothing real is served.
    always_ff @(posedge clk) begin
        if (!rst_n || !take_ok) begin
            px_data    <= DUMMY_PIX;
            px_real    <= 1'b0;
            frame_done <= 1'b0;
        end else begin
            px_data    <= rd_q;
            px_real    <= 1'b1;
            frame_done <= (scan_pos == POS_W'(FRAME - 1));
        end
    end

endmodule

// File: rtl/pingpong_scanout.sv
`timescale 1ns/1ps
// Ping-pong line buffer scanout controller: top level tying the bank store,
// the per-buffer fill bookkeeping and the scanout sequencer together.
// Assumes: H_RES*V_RES is a multiple of BUF_PIX and at least 2*BUF_PIX,
// BUF_PIX is a power of two and PIX_W is a multiple of 8.
module pingpong_scanout #(
    parameter int               PIX_W     = 16,
    parameter int               BUF_PIX   = 8,
    parameter int               H_RES     = 8,
    parameter int               V_RES     = 4,
    parameter logic [PIX_W-1:0] DUMMY_PIX = '0,
    localparam int FRAME  = H_RES * V_RES,
    localparam int POS_W  = $clog2(FRAME),
    localparam int ADDR_W = $clog2(BUF_PIX),
    localparam int BYTES  = BUF_PIX * (PIX_W / 8),
    localparam int LEN_W  = $clog2(BYTES + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               vsync,
    input  logic               restart_req,
    input  logic               auto_restart,
    input  logic               px_take,
    output logic [PIX_W-1:0]   px_data,
    output logic               px_real,
    output logic               frame_done,
    output logic               underrun,
    output logic [1:0]         fill_req,
    output logic [2*POS_W-1:0] fill_pos,
    output logic [LEN_W-1:0]   fill_len,
    input  logic [1:0]         fill_ack,
    input  logic               wr_en,
    input  logic               wr_sel,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [PIX_W-1:0]   wr_data
);

    logic                  rd_sel;
    logic [ADDR_W-1:0]     rd_addr;
    logic [PIX_W-1:0]      rd_q;
    logic                  drain;
    logic                  restart_apply;
    logic [1:0]            full;
    logic [1:0][POS_W-1:0] pos;

    assign fill_len = LEN_W'(BYTES);
    assign fill_pos = pos;

    pp_bank_store #(.PIX_W(PIX_W), .DEPTH(BUF_PIX)) u_store (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_sel  (rd_sel),
        .rd_addr (rd_addr),
        .rd_data (rd_q)
    );

    pp_fill_ctrl #(.BUF_PIX(BUF_PIX), .FRAME(FRAME), .POS_W(POS_W)) u_fill (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (restart_apply),
        .drain     (drain),
        .drain_sel (rd_sel),
        .ack       (fill_ack),
        .full      (full),
        .req       (fill_req),
        .pos       (pos)
    );

    pp_scan_seq #(
        .PIX_W(PIX_W), .BUF_PIX(BUF_PIX), .FRAME(FRAME),
        .POS_W(POS_W), .DUMMY_PIX(DUMMY_PIX)
    ) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .vsync         (vsync),
        .restart_req   (restart_req),
        .auto_restart  (auto_restart),
        .px_take       (px_take),
        .full          (full),
        .rd_q          (rd_q),
        .rd_sel        (rd_sel),
        .rd_addr       (rd_addr),
        .drain         (drain),
        .restart_apply (restart_apply),
        .px_data       (px_data),
        .px_real       (px_real),
        .frame_done    (frame_done),
        .underrun      (underrun)
    );

endmodule

// File: rtl/pp_scan_checker.sv
`timescale 1ns/1ps
// Protocol checker for the scanout controller, bound into the top module.
// Assumes: rst_n is held low for at least one clock at start.
module pp_scan_checker #(
    parameter int PW = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          px_take,
    input logic          px_real,
    input logic          frame_done,
    input logic          underrun,
    input logic          restart_apply,
    input logic [1:0]    fill_req,
    input logic [1:0]    fill_ack,
    input logic [PW-1:0] fill_pos
);

    p_ack_full0_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_ack[0] && fill_req[0] && !restart_apply) |=> !fill_req[0]);

    p_ack_full1_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_ack[1] && fill_req[1] && !restart_apply) |=> !fill_req[1]);

    p_real_from_take_r4: assert property (@(posedge clk) disable iff (!rst_n)
        px_real |-> $past(px_take));

    p_frame_done_real_r6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> px_real);

    p_dummy_in_underrun_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (underrun && px_take) |=> !px_real);

    p_underrun_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (underrun && !restart_apply) |=> underrun);

    p_pos_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart_apply && !px_take) |=> $stable(fill_pos));

    p_restart_realign_r10: assert property (@(posedge clk) disable iff (!rst_n)
        restart_apply |=> (!underrun && (fill_req == 2'b11)));

endmodule

bind pingpong_scanout pp_scan_checker #(.PW(2 * POS_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .px_take       (px_take),
    .px_real       (px_real),
    .frame_done    (frame_done),
    .underrun      (underrun),
    .restart_apply (restart_apply),
    .fill_req      (fill_req),
    .fill_ack      (fill_ack),
    .fill_pos      (fill_pos)
);

// File: tb/pingpong_scanout_test.sv
`timescale 1ns/1ps
// Directed bench for the ping-pong scanout controller, default parameters.
module pingpong_scanout_test;

    localparam int PIX_W = 16;
    localparam int BUFP  = 8;
    localparam int FRAME = 32;
    localparam int POS_W = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              vsync = 1'b0;
    logic              restart_req = 1'b0;
    logic              auto_restart = 1'b0;
    logic              px_take = 1'b0;
    logic [PIX_W-1:0]  px_data;
    logic              px_real;
    logic              frame_done;
    logic              underrun;
    logic [1:0]        fill_req;
    logic [2*POS_W-1:0] fill_pos;
    logic [4:0]        fill_len;
    logic [1:0]        fill_ack = 2'b00;
    logic              wr_en = 1'b0;
    logic              wr_sel = 1'b0;
    logic [2:0]        wr_addr = '0;
    logic [PIX_W-1:0]  wr_data = '0;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = !clk;

    pingpong_scanout uut (
        .clk(clk), .rst_n(rst_n), .vsync(vsync), .restart_req(restart_req),
        .auto_restart(auto_restart), .px_take(px_take), .px_data(px_data),
        .px_real(px_real), .frame_done(frame_done), .underrun(underrun),
        .fill_req(fill_req), .fill_pos(fill_pos), .fill_len(fill_len),
        .fill_ack(fill_ack), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_addr(wr_addr), .wr_data(wr_data)
    );

    function automatic logic [PIX_W-1:0] pix_val(input int p);
        return 16'hA000 + 16'(p % FRAME);
    endfunction

    function automatic int pos_of(input int b);
        return int'(fill_pos[b*POS_W +: POS_W]);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic fill_buf(input int b);
        int p;
        p = pos_of(b);
        for (int i = 0; i < BUFP; i++) begin
            wr_en = 1'b1; wr_sel = 1'(b); wr_addr = 3'(i); wr_data = pix_val(p + i);
            @(negedge clk);
        end
        wr_en = 1'b0;
        fill_ack[b] = 1'b1;
        @(negedge clk);
        fill_ack = 2'b00;
        chk("R3 req drops after ack", int'(fill_req[b]), 0);
    endtask

    task automatic take_px(input bit exp_real, input int exp_p, input bit exp_fd,
                           input string req);
        px_take = 1'b1;
        @(negedge clk);
        px_take = 1'b0;
        chk({req, " px_real"}, int'(px_real), int'(exp_real));
        chk({req, " px_data"}, int'(px_data), exp_real ? int'(pix_val(exp_p)) : 0);
        chk("R6 frame_done", int'(frame_done), int'(exp_fd));
    endtask

    task automatic pulse_vsync(input bit with_req);
        vsync = 1'b1; restart_req = with_req;
        @(negedge clk);
        vsync = 1'b0; restart_req = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 fill_req", int'(fill_req), 3);
        chk("R1 pos0", pos_of(0), 0);
        chk("R1 pos1", pos_of(1), BUFP);
        chk("R1 underrun", int'(underrun), 0);
        chk("R1 px_real", int'(px_real), 0);
        chk("R1 frame_done", int'(frame_done), 0);
        chk("R2 fill_len", int'(fill_len), 16);
    endtask

    task automatic t_stream;
        fill_buf(0);
        chk("R3 other still requested", int'(fill_req), 2);
        fill_buf(1);
        for (int k = 0; k < FRAME; k++) begin
            take_px(1'b1, k, k == FRAME - 1, "R4 stream");
            if (k % BUFP == BUFP - 1) begin
                chk("R5 drained buffer requested", int'(fill_req[(k / BUFP) % 2]), 1);
                chk("R5 refill position", pos_of((k / BUFP) % 2), (k + 1 + BUFP) % FRAME);
                fill_buf((k / BUFP) % 2);
            end
        end
        for (int k = 0; k < 4; k++) take_px(1'b1, k, 1'b0, "R5 wrap to frame start");
    endtask

    task automatic t_underrun;
        for (int k = 4; k < 16; k++) take_px(1'b1, k, 1'b0, "R4 drain both");
        chk("R7 underrun at swap", int'(underrun), 1);
        take_px(1'b0, 0, 1'b0, "R7 dummy");
        take_px(1'b0, 0, 1'b0, "R7 dummy no advance");
        fill_buf(0);
        fill_buf(1);
        chk("R8 underrun after fills", int'(underrun), 1);
        take_px(1'b0, 0, 1'b0, "R8 still dummy");
        pulse_vsync(1'b0);
        chk("R9 bare vsync underrun", int'(underrun), 1);
        chk("R9 bare vsync requests", int'(fill_req), 0);
        restart_req = 1'b1; @(negedge clk); restart_req = 1'b0;
        chk("R9 latched request underrun", int'(underrun), 1);
        chk("R9 latched request requests", int'(fill_req), 0);
        chk("R9 latched request pos0", pos_of(0), 16);
        pulse_vsync(1'b0);
        chk("R10 underrun cleared", int'(underrun), 0);
        chk("R10 requests", int'(fill_req), 3);
        chk("R10 pos0", pos_of(0), 0);
        chk("R10 pos1", pos_of(1), BUFP);
        fill_buf(0);
        fill_buf(1);
        for (int k = 0; k < 3; k++) take_px(1'b1, k, 1'b0, "R10 realigned");
    endtask

    task automatic t_auto;
        auto_restart = 1'b1;
        pulse_vsync(1'b0);
        chk("R11 auto requests", int'(fill_req), 3);
        chk("R11 auto pos0", pos_of(0), 0);
        fill_buf(0);
        fill_buf(1);
        take_px(1'b1, 0, 1'b0, "R11 auto realigned");
        auto_restart = 1'b0;
        pulse_vsync(1'b0);
        chk("R9 vsync without auto", int'(fill_req), 0);
        take_px(1'b1, 1, 1'b0, "R9 vsync without auto");
    endtask

    task automatic t_start_underrun;
        pulse_vsync(1'b1);
        chk("R9 coincident request applied", int'(fill_req), 3);
        take_px(1'b0, 0, 1'b0, "R7 take on empty buffer");
        chk("R7 underrun on empty take", int'(underrun), 1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_stream();
        t_underrun();
        t_auto();
        t_start_underrun();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule